// File: doc/BRIEF.md
# USB Debug Port Transaction Scheduler

This block sits beside one root port of a USB 2.0 host controller and decides when the debug engine may start a debug transaction on that port. It polls a pending-request flag from debug software on a fixed microsecond cadence. It grants one transaction at a time, and it keeps the attached debug console from suspending.

When the normal host schedule is not producing start-of-frame traffic on the port, the scheduler asks the transmitter for a standalone 32-bit SYNC keepalive at a fixed interval. That happens when the controller is halted or the port is disabled from the normal driver's view. When the controller runs with the port enabled, regular SOFs keep the device awake and no keepalive is asked for.

After a port reset, or a suspend/resume sequence, debug traffic is held off. The hold-off lasts until the first SOF strobe that follows the end of the event.

Top module: `usb_dbg_sched`

## Requirements
- R1: While the port is usable, the pending request is examined once every POLL_US microsecond ticks (default 100, within a 125 us bound). With the request held high and each transaction completing before the next poll, exactly one single-cycle grant is given per POLL_US ticks.
- R2: The port is usable only when dbg_en=1, pwr_d0=1, port_suspend=0 and port_reset=0. While it is not usable, no grant and no keepalive request occur.
- R3: In keepalive mode (usable, and not both hc_run=1 and port_enabled=1), ka_req rises after KA_US ticks (default 1000, under 2000) with no completed transaction. It then stays high until ka_done.
- R4: When hc_run=1 and port_enabled=1, ka_req is never raised.
- R5: A xfer_done strobe restarts the keepalive interval, so steady debug traffic produces no keepalive requests.
- R6: No grant is given while a granted transaction has not yet signalled xfer_done, while ka_req is high, or while holdoff is high.
- R7: port_reset=1 or port_suspend=1 sets holdoff at the next clock edge. holdoff stays high for the whole event, and sof_sent strobes during the event do not clear it.
- R8: After the event ends, holdoff stays high until the first sof_sent strobe and clears on the edge that samples it. Grants then resume.
- R9: port_enabled has no effect on whether grants are given.
- R10: After reset, dbg_grant, ka_req and holdoff are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| hc_run | input | 1 | Host controller run/stop state, 1 = running |
| port_enabled | input | 1 | Port enable as seen by the normal host driver |
| port_suspend | input | 1 | Port is in suspend or resume signalling |
| port_reset | input | 1 | Port is driving USB reset |
| pwr_d0 | input | 1 | Controller is in the D0 power state |
| dbg_en | input | 1 | Debug enable, held apart from the port enable |
| dbg_req | input | 1 | Debug software has a transaction pending |
| sof_sent | input | 1 | Strobe: an SOF packet was sent on the port |
| xfer_done | input | 1 | Strobe: the granted debug transaction finished |
| ka_done | input | 1 | Strobe: the keepalive SYNC was sent |
| dbg_grant | output | 1 | Single-cycle permission to start a debug transaction |
| ka_req | output | 1 | Request to send a standalone keepalive SYNC |
| holdoff | output | 1 | Debug transactions are held off after reset or suspend |

## Verification
The hardest state to reach from the ports is the window after a reset or resume has ended but before any SOF has been seen. In that window the port is usable again and polls fire, yet grants must stay blocked. The stimulus holds a request pending and drives reset, then suspend. It pulses sof_sent while each event is still active, then releases the event and runs several poll intervals with no SOF. Only after that does it send the releasing SOF and count the grants that follow.

// File: rtl/dbg_sched_pkg.sv
`timescale 1ns/1ps
package dbg_sched_pkg;

  typedef enum logic [1:0] {
    HO_CLEAR    = 2'd0,
    HO_EVENT    = 2'd1,
    HO_WAIT_SOF = 2'd2
  } holdoff_st_e;

  // Port may carry debug traffic at all.
  function automatic logic port_usable(input logic en, input logic d0,
                                       input logic susp, input logic rst);
    return en & d0 & ~susp & ~rst;
  endfunction

  // Normal SOF traffic keeps the device awake only when running and enabled.
  function automatic logic needs_keepalive(input logic usable, input logic run,
                                           input logic pen);
    return usable & ~(run & pen);
  endfunction

  // Grant decision at a poll instant.
  function automatic logic may_grant(input logic poll, input logic req,
                                     input logic ka, input logic ho,
                                     input logic usable, input logic busy);
    return poll & req & ~ka & ~ho & usable & ~busy;
  endfunction

  // Interval counter step: wraps to zero on the last tick.
  function automatic int unsigned step_count(input int unsigned cnt,
                                             input int unsigned last);
    return (cnt == last) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/dbg_us_timer.sv
`timescale 1ns/1ps
module dbg_us_timer #(
  parameter int TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic fire
);
  import dbg_sched_pkg::*;

  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = tick & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (!run || restart) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= wrap;
      if (tick) cnt <= CW'(step_count(int'(cnt), int'(LAST)));
    end
  end

  // R1: interval counter never leaves its range
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R1: a fire pulse only follows a counted tick
  assert_fire_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(tick));

endmodule

// File: rtl/dbg_holdoff.sv
`timescale 1ns/1ps
module dbg_holdoff (
  input  logic clk,
  input  logic rst_n,
  input  logic port_reset,
  input  logic port_suspend,
  input  logic sof_sent,
  output logic holdoff
);
  import dbg_sched_pkg::*;

  holdoff_st_e st, st_nx;
  logic        event_on;

  assign event_on = port_reset | port_suspend;

  always_comb begin
    st_nx = st;
    case (st)
      HO_CLEAR:    if (event_on) st_nx = HO_EVENT;
      HO_EVENT:    if (!event_on) st_nx = HO_WAIT_SOF;
      HO_WAIT_SOF: begin
        if (event_on)      st_nx = HO_EVENT;
        else if (sof_sent) st_nx = HO_CLEAR;
      end
      default:     st_nx = HO_EVENT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= HO_CLEAR;
    else        st <= st_nx;
  end

  assign holdoff = (st != HO_CLEAR);

  assert_holdoff_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    event_on |=> holdoff);

  assert_holdoff_waits_sof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (holdoff && !sof_sent) |=> holdoff);

endmodule

// File: rtl/dbg_keepalive.sv
`timescale 1ns/1ps
module dbg_keepalive #(
  parameter int KA_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ka_mode,
  input  logic tick,
  input  logic xfer_done,
  input  logic ka_done,
  output logic ka_req
);

  logic ka_fire;

  dbg_us_timer #(.TICKS(KA_US)) u_ka_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ka_mode),
    .restart (xfer_done),
    .tick    (tick),
    .fire    (ka_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ka_req <= 1'b0;
    else if (!ka_mode) ka_req <= 1'b0;
    else if (ka_fire)  ka_req <= 1'b1;
    else if (ka_done)  ka_req <= 1'b0;
  end

  assert_ka_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ka_req && !ka_done && ka_mode) |=> ka_req);

  assert_ka_only_in_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ka_mode |=> !ka_req);

endmodule

// File: rtl/usb_dbg_sched.sv
`timescale 1ns/1ps
module usb_dbg_sched #(
  parameter int POLL_US = 100,
  parameter int KA_US   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic hc_run,
  input  logic port_enabled,
  input  logic port_suspend,
  input  logic port_reset,
  input  logic pwr_d0,
  input  logic dbg_en,
  input  logic dbg_req,
  input  logic sof_sent,
  input  logic xfer_done,
  input  logic ka_done,
  output logic dbg_grant,
  output logic ka_req,
  output logic holdoff
);
  import dbg_sched_pkg::*;

  logic usable;
  logic ka_mode;
  logic poll_fire;
  logic busy;

  assign usable  = port_usable(dbg_en, pwr_d0, port_suspend, port_reset);
  assign ka_mode = needs_keepalive(usable, hc_run, port_enabled);

  dbg_us_timer #(.TICKS(POLL_US)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (usable),
    .restart (1'b0),
    .tick    (us_tick),
    .fire    (poll_fire)
  );

  dbg_holdoff u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_reset   (port_reset),
    .port_suspend (port_suspend),
    .sof_sent     (sof_sent),
    .holdoff      (holdoff)
  );

  dbg_keepalive #(.KA_US(KA_US)) u_ka (
    .clk       (clk),
    .rst_n     (rst_n),
    .ka_mode   (ka_mode),
    .tick      (us_tick),
    .xfer_done (xfer_done),
    .ka_done   (ka_done),
    .ka_req    (ka_req)
  );

  assign dbg_grant = may_grant(poll_fire, dbg_req, ka_req, holdoff, usable, busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (!usable)   busy <= 1'b0;
    else if (dbg_grant) busy <= 1'b1;
    else if (xfer_done) busy <= 1'b0;
  end

  assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_grant && !xfer_done) |=> !dbg_grant);

  assert_grant_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_grant |-> (!ka_req && !holdoff));

  assert_no_grant_unusable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_d0 || !dbg_en) |-> !dbg_grant);

  assert_no_ka_sof_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_run && port_enabled && !ka_req) |=> !ka_req);

endmodule

// File: tb/sim_usb_dbg_sched.sv
`timescale 1ns/1ps
module sim_usb_dbg_sched;

  localparam int POLL = 4;
  localparam int KA   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1;
  logic hc_run = 1'b0, port_enabled = 1'b0, port_suspend = 1'b0, port_reset = 1'b0;
  logic pwr_d0 = 1'b0, dbg_en = 1'b0, dbg_req = 1'b0;
  logic sof_sent = 1'b0, xfer_done = 1'b0, ka_done = 1'b0;
  logic dbg_grant, ka_req, holdoff;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_dbg_sched #(.POLL_US(POLL), .KA_US(KA)) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .hc_run(hc_run),
    .port_enabled(port_enabled), .port_suspend(port_suspend),
    .port_reset(port_reset), .pwr_d0(pwr_d0), .dbg_en(dbg_en),
    .dbg_req(dbg_req), .sof_sent(sof_sent), .xfer_done(xfer_done),
    .ka_done(ka_done), .dbg_grant(dbg_grant), .ka_req(ka_req),
    .holdoff(holdoff)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input bit run, input bit pen, input bit d0,
                         input bit en, input bit req);
    @(negedge clk);
    dbg_en = 1'b0; xfer_done = 1'b0; ka_done = 1'b0;
    @(negedge clk);
    @(negedge clk);
    hc_run = run; port_enabled = pen; pwr_d0 = d0; dbg_en = en; dbg_req = req;
  endtask

  // Runs n cycles, answering grants (if ack) and keepalives; counts both.
  task automatic run_window(input int n, input bit ack, output int g, output int k);
    int  xcnt;
    logic kprev;
    g = 0; k = 0; xcnt = 0; kprev = ka_req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xfer_done = 1'b0; ka_done = 1'b0;
      if (xcnt > 0) begin
        xcnt--;
        if (xcnt == 0) xfer_done = 1'b1;
      end
      if (dbg_grant) begin
        g++;
        if (ack) xcnt = 2;
      end
      if (ka_req && !kprev) k++;
      if (ka_req) ka_done = 1'b1;
      kprev = ka_req;
    end
    @(negedge clk);
    xfer_done = 1'b0; ka_done = 1'b0;
  endtask

  task automatic event_test(input bit use_reset, input string nm);
    int g, k;
    set_cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    if (use_reset) port_reset = 1'b1; else port_suspend = 1'b1;
    @(negedge clk);
    check(holdoff == 1'b1, {"R7 holdoff set on ", nm}, holdoff, 1);
    run_window(3*POLL, 1'b1, g, k);
    check(g == 0, {"R2 no grant during ", nm}, g, 0);
    sof_sent = 1'b1;
    @(negedge clk);
    sof_sent = 1'b0;
    check(holdoff == 1'b1, {"R7 SOF inside event ignored, ", nm}, holdoff, 1);
    port_reset = 1'b0; port_suspend = 1'b0;
    run_window(3*POLL, 1'b1, g, k);
    check(g == 0, {"R8 no grant before first SOF, ", nm}, g, 0);
    check(holdoff == 1'b1, {"R8 holdoff kept until SOF, ", nm}, holdoff, 1);
    sof_sent = 1'b1;
    @(negedge clk);
    sof_sent = 1'b0;
    check(holdoff == 1'b0, {"R8 holdoff cleared by SOF, ", nm}, holdoff, 0);
    run_window(10*POLL + 2, 1'b1, g, k);
    check(g >= 9, {"R8 grants resume after ", nm}, g, 9);
  endtask

  initial begin
    int g, k, eg, ek;
    bit act, kam;
    repeat (3) @(negedge clk);
    check(dbg_grant == 1'b0, "R10 reset grant", dbg_grant, 0);
    check(ka_req == 1'b0, "R10 reset ka_req", ka_req, 0);
    check(holdoff == 1'b0, "R10 reset holdoff", holdoff, 0);
    rst_n = 1'b1;

    // Sweep: run, port enable, D0, debug enable, request (R1 R2 R3 R4 R5 R9)
    for (int c = 0; c < 32; c++) begin
      set_cfg(c[0], c[1], c[2], c[3], c[4]);
      if (c[4]) run_window(10*POLL + POLL/2, 1'b1, g, k);
      else      run_window(5*KA + KA/2, 1'b1, g, k);
      act = c[2] & c[3];
      kam = act & ~(c[0] & c[1]);
      eg = (act && c[4]) ? 10 : 0;
      ek = (kam && !c[4]) ? 5 : 0;
      check(g == eg, $sformatf("R1 R2 R9 grants cfg=%0d", c), g, eg);
      check(k == ek, $sformatf("R3 R4 R5 keepalives cfg=%0d", c), k, ek);
    end

    // No completion: one outstanding grant only; keepalive not restarted (R6, R5)
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    run_window(5*KA + KA/2, 1'b0, g, k);
    check(g == 1, "R6 single outstanding grant", g, 1);
    check(k == 5, "R5 keepalive when no transaction completes", k, 5);

    event_test(1'b1, "reset");
    event_test(1'b0, "suspend");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule